// File: doc/BRIEF.md
# CPU-to-ISA I/O Window Translator

This block sits between a processor's memory bus and an ISA-style I/O port bus. The processor reaches I/O ports by issuing ordinary loads and stores into an 8 MB region of physical address space starting at 0x8000_0000. The block recognises accesses to that region, turns the offset into a 16-bit port number, and forwards the access to the I/O side as one transaction that carries its direction, size and data. When the I/O side reports completion, the block returns read data to the processor together with a one-cycle ready pulse.

Two port maps are available, chosen by a mode bit that comes from the system control register file. In the flat map the port number is just the low 16 bits of the offset, which gives a dense 64 KB port space. In the paged map each group of 32 ports lives at the bottom of its own 4 KB page. The lowest 5 offset bits are kept, and offset bits 22..12 become port bits 15..5. This lets system software give each small group of ports its own page for protection. The mode is sampled when an access is accepted. Only one access is outstanding at a time.

Top module: `isa_io_window`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `isa_req` and `cpu_ready` are 0, and `cpu_claim` is 0 when `cpu_req` is 0.
- R2: A request is claimed (`cpu_claim` = 1 in the same cycle) only when the block is idle and `cpu_addr` lies in [0x8000_0000, 0x8080_0000). A claimed request raises `isa_req` on the next cycle. A request outside that range is never claimed and starts no I/O transaction.
- R3: With `map_sel` = 0 at acceptance, `isa_port` equals the window offset bits 15..0. Offset bits 22..16 are dropped.
- R4: With `map_sel` = 1 at acceptance, `isa_port[15:5]` equals offset bits 22..12 and `isa_port[4:0]` equals offset bits 4..0. Offset bits 11..5 are dropped.
- R5: `map_sel` is taken only in the cycle a request is accepted. Changing it while a transaction is open leaves `isa_port` unchanged.
- R6: `isa_size` repeats the accepted `cpu_size` (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = treated as 4 bytes), and `isa_we` repeats `cpu_we`. The port number does not depend on the size.
- R7: Data lanes are little-endian: the byte at the lowest address is bits 7..0. `isa_wdata` carries the accepted `cpu_wdata` with lanes beyond the access size forced to 0. For example, with a byte access only bits 7..0 survive, and with a halfword access bits 15..0 survive.
- R8: In the cycle after the edge where `isa_done` is sampled high during a transaction, `cpu_ready` is 1 for exactly one cycle. In that same cycle `cpu_rdata` holds `isa_rdata` from that edge, with lanes beyond the access size forced to 0.
- R9: While a transaction is open, new requests are not claimed. During that time `isa_port`, `isa_size`, `isa_we` and `isa_wdata` hold steady, even if the processor-side inputs change.
- R10: `isa_req` stays high from the cycle after acceptance until the edge where `isa_done` is sampled, and it is low in the cycle that `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_sel | input | 1 | Port map select: 0 flat, 1 paged |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | Access size code |
| cpu_addr | input | 32 | Physical byte address |
| cpu_wdata | input | 32 | Store data, little-endian lanes |
| cpu_claim | output | 1 | Request accepted this cycle |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| isa_req | output | 1 | I/O transaction open |
| isa_we | output | 1 | I/O transaction direction |
| isa_size | output | 2 | I/O transaction size code |
| isa_port | output | 16 | Translated I/O port number |
| isa_wdata | output | 32 | I/O write data, size-masked |
| isa_done | input | 1 | I/O side completion |
| isa_rdata | input | 32 | I/O read data, sampled with isa_done |

## Verification
The bench targets the address bits each map must drop: offset bits 22..16 in the flat map and bits 11..5 in the paged map. It uses addresses at the very top of the window, which must give port 0xFFFF in the paged map. A translator that keeps the wrong bits, or that shifts by the wrong amount, produces a port that mismatches the scoreboard. It also tests addresses one byte on either side of the window, where an off-by-one range test would claim a stray access and open a transaction the scoreboard never queued. The bench flips `map_sel` and changes the store data in mid-transaction, and it fires a second in-window request while the first is still open. A design that re-translates live, fails to latch the data, or accepts a second access would change the port or data on the I/O side, or would open an extra transaction. Loads and stores of every size to one address check that the port does not depend on the size and that upper lanes are zeroed in both directions.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

   localparam int SIZE_W = 2;

   typedef enum logic [SIZE_W-1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } acc_size_e;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } xfer_state_e;

   typedef struct packed {
      logic      we;
      acc_size_e size;
   } acc_attr_t;

   // Number of byte lanes an access of the given size touches.
   function automatic int unsigned lane_count(input logic [SIZE_W-1:0] sz);
      case (sz)
         SZ_BYTE: lane_count = 1;
         SZ_HALF: lane_count = 2;
         default: lane_count = 4;
      endcase
   endfunction

endpackage

// File: rtl/iowin_decode.sv
module iowin_decode #(
   parameter int                ADDR_W   = 32,
   parameter int                OFS_W    = 23,
   parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [OFS_W-1:0]  ofs
);

   localparam int TAG_W = ADDR_W - OFS_W;
   localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:OFS_W];

   // Window is naturally aligned, so a tag compare is the full range test.
   assign hit = (addr[ADDR_W-1:OFS_W] == BASE_TAG);
   assign ofs = addr[OFS_W-1:0];

endmodule

// File: rtl/iowin_xlate.sv
module iowin_xlate #(
   parameter int OFS_W     = 23,
   parameter int PORT_W    = 16,
   parameter int PAGE_LSB  = 12,
   parameter int KEEP_LO   = 5,
   parameter bit SPARSE_EN = 1'b1
) (
   input  logic [OFS_W-1:0]  ofs,
   input  logic              sparse_mode,
   output logic [PORT_W-1:0] port
);

   logic [PORT_W-1:0] flat_port;

   assign flat_port = ofs[PORT_W-1:0];

   generate
      if (SPARSE_EN) begin : g_two_maps
         logic [PORT_W-1:0] paged_port;
         // Page number lands directly above the kept low bits.
         assign paged_port = {ofs[OFS_W-1:PAGE_LSB], ofs[KEEP_LO-1:0]};
         assign port       = sparse_mode ? paged_port : flat_port;
      end else begin : g_flat_only
         logic unused_mode;
         logic [OFS_W-PORT_W-1:0] unused_hi;
         assign unused_mode = sparse_mode;
         assign unused_hi   = ofs[OFS_W-1:PORT_W];
         assign port        = flat_port;
      end
   endgenerate

endmodule

// File: rtl/iowin_lanes.sv
module iowin_lanes
   import iowin_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [SIZE_W-1:0] size,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);

   localparam int LANES = DATA_W / 8;

   logic [LANES-1:0] lane_en;

   generate
      for (genvar j = 0; j < LANES; j++) begin : g_lane
         localparam int unsigned LANE_IDX = j;
         assign lane_en[j]       = (LANE_IDX < lane_count(size));
         assign dout[j*8 +: 8]   = lane_en[j] ? din[j*8 +: 8] : 8'h00;
      end
   endgenerate

endmodule

// File: rtl/iowin_ctrl.sv
module iowin_ctrl
   import iowin_pkg::*;
#(
   parameter int PORT_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              win_hit,
   input  acc_attr_t         attr_in,
   input  logic [PORT_W-1:0] port_in,
   input  logic [DATA_W-1:0] wdata_in,
   input  logic              io_done,
   input  logic [DATA_W-1:0] rdata_in,
   output logic              accept,
   output logic              io_open,
   output acc_attr_t         attr_q,
   output logic [PORT_W-1:0] port_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              ready_q,
   output logic [DATA_W-1:0] rdata_q
);

   xfer_state_e state;

   assign accept  = cpu_req && win_hit && (state == ST_IDLE);
   assign io_open = (state == ST_WAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         attr_q  <= '0;
         port_q  <= '0;
         wdata_q <= '0;
         ready_q <= 1'b0;
         rdata_q <= '0;
      end else begin
         ready_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  state   <= ST_WAIT;
                  attr_q  <= attr_in;
                  port_q  <= port_in;
                  wdata_q <= wdata_in;
               end
            end
            ST_WAIT: begin
               if (io_done) begin
                  state   <= ST_IDLE;
                  ready_q <= 1'b1;
                  rdata_q <= rdata_in;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/isa_io_window.sv
module isa_io_window
   import iowin_pkg::*;
#(
   parameter int                ADDR_W    = 32,
   parameter int                DATA_W    = 32,
   parameter int                PORT_W    = 16,
   parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] WIN_BYTES = 32'h0080_0000,
   parameter int                PAGE_LSB  = 12,
   parameter int                KEEP_LO   = 5,
   parameter bit                SPARSE_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                map_sel,
   input  logic                cpu_req,
   input  logic                cpu_we,
   input  logic [SIZE_W-1:0]   cpu_size,
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic [DATA_W-1:0]   cpu_wdata,
   output logic                cpu_claim,
   output logic                cpu_ready,
   output logic [DATA_W-1:0]   cpu_rdata,
   output logic                isa_req,
   output logic                isa_we,
   output logic [SIZE_W-1:0]   isa_size,
   output logic [PORT_W-1:0]   isa_port,
   output logic [DATA_W-1:0]   isa_wdata,
   input  logic                isa_done,
   input  logic [DATA_W-1:0]   isa_rdata
);

   localparam int OFS_W     = $clog2(WIN_BYTES);
   localparam int PAGED_W   = OFS_W - PAGE_LSB + KEEP_LO;

   // Elaboration-time parameter checks
   generate
      if ((WIN_BYTES & (WIN_BYTES - 1'b1)) != '0) begin : g_chk_pow2
         $error("isa_io_window: WIN_BYTES must be a power of two");
      end
      if ((WIN_BASE & (WIN_BYTES - 1'b1)) != '0) begin : g_chk_align
         $error("isa_io_window: WIN_BASE must be aligned to WIN_BYTES");
      end
      if (OFS_W < PORT_W || OFS_W >= ADDR_W) begin : g_chk_ofs
         $error("isa_io_window: window offset width out of range");
      end
      if (DATA_W < 32 || (DATA_W % 8) != 0) begin : g_chk_data
         $error("isa_io_window: DATA_W must be a byte multiple of at least 32");
      end
      if (SPARSE_EN && (PAGED_W != PORT_W || KEEP_LO > PAGE_LSB)) begin : g_chk_paged
         $error("isa_io_window: paged map does not fill the port width");
      end
   endgenerate

   logic              win_hit;
   logic [OFS_W-1:0]  win_ofs;
   logic [PORT_W-1:0] xl_port;
   logic [DATA_W-1:0] wdata_mask;
   logic [DATA_W-1:0] rdata_mask;
   acc_attr_t         attr_in;
   acc_attr_t         attr_q;

   assign attr_in.we   = cpu_we;
   assign attr_in.size = acc_size_e'(cpu_size);

   iowin_decode #(
      .ADDR_W   (ADDR_W),
      .OFS_W    (OFS_W),
      .WIN_BASE (WIN_BASE)
   ) u_decode (
      .addr (cpu_addr),
      .hit  (win_hit),
      .ofs  (win_ofs)
   );

   iowin_xlate #(
      .OFS_W     (OFS_W),
      .PORT_W    (PORT_W),
      .PAGE_LSB  (PAGE_LSB),
      .KEEP_LO   (KEEP_LO),
      .SPARSE_EN (SPARSE_EN)
   ) u_xlate (
      .ofs         (win_ofs),
      .sparse_mode (map_sel),
      .port        (xl_port)
   );

   iowin_lanes #(.DATA_W(DATA_W)) u_wlanes (
      .size (cpu_size),
      .din  (cpu_wdata),
      .dout (wdata_mask)
   );

   iowin_lanes #(.DATA_W(DATA_W)) u_rlanes (
      .size (isa_size),
      .din  (isa_rdata),
      .dout (rdata_mask)
   );

   iowin_ctrl #(
      .PORT_W (PORT_W),
      .DATA_W (DATA_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_req  (cpu_req),
      .win_hit  (win_hit),
      .attr_in  (attr_in),
      .port_in  (xl_port),
      .wdata_in (wdata_mask),
      .io_done  (isa_done),
      .rdata_in (rdata_mask),
      .accept   (cpu_claim),
      .io_open  (isa_req),
      .attr_q   (attr_q),
      .port_q   (isa_port),
      .wdata_q  (isa_wdata),
      .ready_q  (cpu_ready),
      .rdata_q  (cpu_rdata)
   );

   assign isa_we   = attr_q.we;
   assign isa_size = attr_q.size;

endmodule

// File: rtl/isa_io_window_chk.sv
module isa_io_window_chk #(
   parameter int DATA_W    = 32,
   parameter int PORT_W    = 16,
   parameter int OFS_W     = 23,
   parameter int PAGE_LSB  = 12,
   parameter int KEEP_LO   = 5,
   parameter bit SPARSE_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              map_sel,
   input logic              cpu_we,
   input logic [1:0]        cpu_size,
   input logic [OFS_W-1:0]  cpu_ofs,
   input logic              cpu_claim,
   input logic              cpu_ready,
   input logic              isa_req,
   input logic              isa_we,
   input logic [1:0]        isa_size,
   input logic [PORT_W-1:0] isa_port,
   input logic [DATA_W-1:0] isa_wdata,
   input logic              isa_done
);

   // Reference paged mapping, built bit by bit.
   function automatic logic [PORT_W-1:0] paged_ref(input logic [OFS_W-1:0] o);
      logic [PORT_W-1:0] r;
      for (int i = 0; i < PORT_W; i++) begin
         r[i] = (i < KEEP_LO) ? o[i] : o[i - KEEP_LO + PAGE_LSB];
      end
      return r;
   endfunction

   // R2
   claim_starts_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_claim |=> isa_req);

   // R2
   no_stray_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!isa_req && !cpu_claim) |=> !isa_req);

   // R3
   flat_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_claim && !map_sel) |=> (isa_port == $past(cpu_ofs[PORT_W-1:0])));

   generate
      if (SPARSE_EN) begin : g_paged_chk
         // R4
         paged_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_claim && map_sel) |=> (isa_port == $past(paged_ref(cpu_ofs))));
      end
   endgenerate

   // R6
   attr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_claim |=> (isa_size == $past(cpu_size) && isa_we == $past(cpu_we)));

   // R7
   byte_lane_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_claim && cpu_size == 2'd0) |=> (isa_wdata[DATA_W-1:8] == '0));

   // R8
   ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |=> !cpu_ready);

   // R8
   ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> $past(isa_req && isa_done));

   // R9
   busy_no_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      isa_req |-> !cpu_claim);

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (isa_req && !isa_done) |=> (isa_req && $stable(isa_port) && $stable(isa_size)
                                  && $stable(isa_we) && $stable(isa_wdata)));

   // R10
   done_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (isa_req && isa_done) |=> (cpu_ready && !isa_req));

endmodule

bind isa_io_window isa_io_window_chk #(
   .DATA_W    (DATA_W),
   .PORT_W    (PORT_W),
   .OFS_W     (OFS_W),
   .PAGE_LSB  (PAGE_LSB),
   .KEEP_LO   (KEEP_LO),
   .SPARSE_EN (SPARSE_EN)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .map_sel   (map_sel),
   .cpu_we    (cpu_we),
   .cpu_size  (cpu_size),
   .cpu_ofs   (cpu_addr[OFS_W-1:0]),
   .cpu_claim (cpu_claim),
   .cpu_ready (cpu_ready),
   .isa_req   (isa_req),
   .isa_we    (isa_we),
   .isa_size  (isa_size),
   .isa_port  (isa_port),
   .isa_wdata (isa_wdata),
   .isa_done  (isa_done)
);

// File: tb/sim_isa_io_window.sv
module sim_isa_io_window;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        map_sel = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [1:0]  cpu_size = 2'd0;
   logic [31:0] cpu_addr = 32'h0;
   logic [31:0] cpu_wdata = 32'h0;
   logic        cpu_claim;
   logic        cpu_ready;
   logic [31:0] cpu_rdata;
   logic        isa_req;
   logic        isa_we;
   logic [1:0]  isa_size;
   logic [15:0] isa_port;
   logic [31:0] isa_wdata;
   logic        isa_done = 1'b0;
   logic [31:0] isa_rdata = 32'h0;

   always #2.5 clk = ~clk;

   isa_io_window u0 (
      .clk(clk), .rst_n(rst_n), .map_sel(map_sel),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_claim(cpu_claim), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
      .isa_req(isa_req), .isa_we(isa_we), .isa_size(isa_size),
      .isa_port(isa_port), .isa_wdata(isa_wdata),
      .isa_done(isa_done), .isa_rdata(isa_rdata)
   );

   typedef struct {
      logic [15:0] port;
      logic [1:0]  size;
      logic        we;
      logic [31:0] wdata;
      logic [31:0] rresp;
      logic [31:0] rexp;
      int          lat;
      string       tag;
   } item_t;

   item_t sb_q[$];
   int    n_chk = 0;
   int    n_fail = 0;
   int    txn_done = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // Little-endian lane mask by size code (R7, R8)
   function automatic logic [31:0] lane_mask(input logic [31:0] d, input logic [1:0] sz);
      case (sz)
         2'd0:    return {24'h0, d[7:0]};
         2'd1:    return {16'h0, d[15:0]};
         default: return d;
      endcase
   endfunction

   // Port expected per R3 / R4
   function automatic logic [15:0] exp_port(input logic [31:0] a, input logic m);
      return m ? {a[22:12], a[4:0]} : a[15:0];
   endfunction

   // Driver: push expected item, present request, optionally disturb it.
   task automatic access(input logic [31:0] addr, input logic [1:0] size,
                         input logic we, input logic [31:0] wdata,
                         input logic [31:0] rresp, input logic mode,
                         input bit flip, input int lat, input bit probe,
                         input string tag);
      item_t it;
      int    start;
      it.port  = exp_port(addr, mode);
      it.size  = size;
      it.we    = we;
      it.wdata = lane_mask(wdata, size);
      it.rresp = rresp;
      it.rexp  = lane_mask(rresp, size);
      it.lat   = lat;
      it.tag   = tag;
      start    = txn_done;
      @(negedge clk);
      map_sel   = mode;
      cpu_req   = 1'b1;
      cpu_addr  = addr;
      cpu_size  = size;
      cpu_we    = we;
      cpu_wdata = wdata;
      sb_q.push_back(it);
      #1 chk(cpu_claim === 1'b1, "R2 in-window claim", {31'h0, cpu_claim}, 32'h1);
      @(negedge clk);
      cpu_req   = 1'b0;
      cpu_wdata = ~wdata;
      cpu_size  = ~size;
      cpu_we    = ~we;
      if (flip) map_sel = ~mode;
      if (probe) begin
         cpu_req  = 1'b1;
         cpu_addr = addr ^ 32'h0000_1010;
         #1 chk(cpu_claim === 1'b0, "R9 claim while busy", {31'h0, cpu_claim}, 32'h0);
         @(negedge clk);
         cpu_req = 1'b0;
      end
      wait (txn_done == start + 1);
   endtask

   task automatic miss(input logic [31:0] addr);
      @(negedge clk);
      cpu_req  = 1'b1;
      cpu_addr = addr;
      cpu_size = 2'd2;
      #1 chk(cpu_claim === 1'b0, "R2 out-of-window claim", {31'h0, cpu_claim}, 32'h0);
      @(negedge clk);
      cpu_req = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(isa_req === 1'b0, "R2 no transaction for miss", {31'h0, isa_req}, 32'h0);
      end
   endtask

   // Monitor and I/O-side responder: pops scoreboard on each new transaction.
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         if (rst_n && isa_req) begin
            if (sb_q.size() == 0) begin
               chk(1'b0, "R9 unexpected transaction", {16'h0, isa_port}, 32'h0);
               it.port = isa_port; it.size = isa_size; it.we = isa_we;
               it.wdata = isa_wdata; it.rresp = 32'h0; it.rexp = 32'h0;
               it.lat = 0; it.tag = "R9";
            end else begin
               it = sb_q.pop_front();
            end
            chk(isa_port === it.port, it.tag, {16'h0, isa_port}, {16'h0, it.port});
            chk(isa_size === it.size && isa_we === it.we, "R6 size/direction",
                {27'h0, isa_we, 2'b0, isa_size}, {27'h0, it.we, 2'b0, it.size});
            if (it.we)
               chk(isa_wdata === it.wdata, "R7 write lanes", isa_wdata, it.wdata);
            for (int k = 0; k < it.lat; k++) begin
               @(negedge clk);
               chk(isa_req === 1'b1, "R10 request held", {31'h0, isa_req}, 32'h1);
               chk(isa_port === it.port, "R5 port held", {16'h0, isa_port}, {16'h0, it.port});
               if (it.we)
                  chk(isa_wdata === it.wdata, "R9 data held", isa_wdata, it.wdata);
            end
            isa_done  = 1'b1;
            isa_rdata = it.rresp;
            @(negedge clk);
            isa_done  = 1'b0;
            isa_rdata = 32'hDEAD_BEEF;
            chk(cpu_ready === 1'b1, "R8 ready pulse", {31'h0, cpu_ready}, 32'h1);
            chk(isa_req === 1'b0, "R10 request dropped", {31'h0, isa_req}, 32'h0);
            if (!it.we)
               chk(cpu_rdata === it.rexp, "R8 read lanes", cpu_rdata, it.rexp);
            txn_done++;
         end
      end
   end

   // Watchdog
   initial begin
      repeat (50000) @(posedge clk);
      chk(1'b0, "watchdog expired", 32'h0, 32'h1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(isa_req === 1'b0 && cpu_ready === 1'b0, "R1 reset outputs",
          {30'h0, isa_req, cpu_ready}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(isa_req === 1'b0 && cpu_ready === 1'b0 && cpu_claim === 1'b0,
          "R1 after release", {29'h0, isa_req, cpu_ready, cpu_claim}, 32'h0);

      // R3 flat map
      access(32'h8000_03F8, 2'd0, 1'b0, 32'h0, 32'h1234_5678, 1'b0, 1'b0, 1, 1'b0, "R3 flat byte");
      access(32'h8071_1234, 2'd1, 1'b1, 32'hA1B2_C3D4, 32'h0, 1'b0, 1'b0, 0, 1'b0, "R3 flat drops 22..16");
      // R7 lanes on writes
      access(32'h8000_0060, 2'd2, 1'b1, 32'hA1B2_C3D4, 32'h0, 1'b0, 1'b0, 2, 1'b0, "R7 word write");
      access(32'h8000_0060, 2'd0, 1'b1, 32'h1122_3344, 32'h0, 1'b0, 1'b0, 1, 1'b0, "R7 byte write");
      access(32'h8000_0060, 2'd3, 1'b1, 32'h5566_7788, 32'h0, 1'b0, 1'b0, 0, 1'b0, "R6 code 3 as word");
      // R4 paged map
      access(32'h800A_5013, 2'd0, 1'b0, 32'h0, 32'h0000_00AB, 1'b1, 1'b0, 1, 1'b0, "R4 paged");
      access(32'h807F_FFFF, 2'd0, 1'b1, 32'hFFFF_FF5C, 32'h0, 1'b1, 1'b0, 0, 1'b0, "R4 top of window");
      access(32'h8000_0FE0, 2'd1, 1'b0, 32'h0, 32'h0BAD_CAFE, 1'b1, 1'b0, 0, 1'b0, "R4 drops 11..5");
      // R5 mode flip in flight, both directions
      access(32'h8012_3456, 2'd2, 1'b1, 32'h0F0F_1234, 32'h0, 1'b1, 1'b1, 3, 1'b0, "R5 paged then flip");
      access(32'h8012_3456, 2'd2, 1'b0, 32'h0, 32'h7654_3210, 1'b0, 1'b1, 3, 1'b0, "R5 flat then flip");
      // R6 / R8 one address, every size
      access(32'h8000_0170, 2'd0, 1'b0, 32'h0, 32'hCAFE_F00D, 1'b0, 1'b0, 1, 1'b0, "R6 byte read");
      access(32'h8000_0170, 2'd1, 1'b0, 32'h0, 32'hCAFE_F00D, 1'b0, 1'b0, 1, 1'b0, "R6 half read");
      access(32'h8000_0170, 2'd2, 1'b0, 32'h0, 32'hCAFE_F00D, 1'b0, 1'b0, 1, 1'b0, "R6 word read");
      // R9 second request while busy
      access(32'h8000_0398, 2'd0, 1'b1, 32'h0000_0042, 32'h0, 1'b0, 1'b0, 3, 1'b1, "R9 busy probe");
      // R2 window edges
      miss(32'h7FFF_FFFF);
      miss(32'h8080_0000);
      miss(32'h0000_03F8);
      access(32'h8000_0000, 2'd0, 1'b0, 32'h0, 32'h0000_0011, 1'b0, 1'b0, 0, 1'b0, "R2 lowest address");

      repeat (3) @(negedge clk);
      chk(sb_q.size() == 0, "R9 scoreboard drained", sb_q.size(), 32'h0);
      summary();
   end

endmodule